// File: doc/BRIEF.md
# Asynchronous Host Bus Port with Self-Completing Acknowledge

This block connects a switch core to an external non-multiplexed asynchronous host bus. The host drives an active-low chip select, an active-low data strobe, a read/write line, a 15-bit address and a 16-bit write word. The port returns a 16-bit read word and an active-low transfer acknowledge. The top address bit chooses between two spaces. One is a small bank of control registers. The other holds four 4096-word memories: two connection memories and two data memories, one of each for the backplane side and one of each for the local side.

The strobes are brought into the core clock domain through synchronizers. A state machine then performs one access and raises the acknowledge. It will not start another access until both strobes have been seen inactive. The switching core has its own port: it writes the two data memories and reads any of the four memories. The host can only read the data memories.

A second, clock-independent path runs from a free-running watchdog clock. It times every active strobe. If the core never answers, for example because its clock is missing, this path raises the acknowledge itself so the host bus cannot hang. The read word returned in that case carries no meaning.

Top module: `hbus_port`

## Requirements
- R1: With address bit 14 low, address bits 13..0 index the register bank. Indices 0 to 7 are 16-bit read/write registers. Any other index reads as 0x0000, and writes to it are dropped.
- R2: With address bit 14 high, bits 13..12 pick a memory and bits 11..0 pick one of its 4096 words. The codes are: 00 backplane connection, 01 backplane data, 10 local connection, 11 local data.
- R3: The host can write and read back both connection memories at any word address, and words at different addresses do not disturb each other.
- R4: A host write to a data memory is acknowledged like any other access, but it leaves the memory unchanged. A host read of a data memory returns what the core wrote there.
- R5: A core write with `core_wr_sel` = 0 goes to the backplane data memory, and with 1 to the local data memory. A core read uses the same 2-bit memory codes as R2, and the word appears on `core_rd_data` one core clock after the address is presented.
- R6: An access starts when `cs_n` and `ds_n` are both low. While the core clock runs, `dta_n` goes low within 8 core clock periods. For a read, `rdata` already holds the addressed word at that moment.
- R7: `dta_n` returns high after either `cs_n` or `ds_n` goes high.
- R8: The core starts a new access only after it has seen `cs_n` and `ds_n` both high. If `ds_n` is lowered again while `cs_n` stays low, the core gives no acknowledge and performs no write.
- R9: With the core clock stopped, an access is still acknowledged. This happens between 600 ns and 1000 ns after the strobe at the default 32-cycle watchdog setting with a 20 ns watchdog clock. The read word is then undefined. Normal operation resumes once the clock returns.
- R10: `rdata_oe` is high exactly while `cs_n` and `ds_n` are low and `rw` is 1 (read); it is low for writes and when idle.
- R11: After reset, `dta_n` is high, `rdata` is 0x0000 and every register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_clk | input | 1 | Free-running watchdog clock, independent of clk |
| cs_n | input | 1 | Host chip select, active low |
| ds_n | input | 1 | Host data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 15 | Host address |
| wdata | input | 16 | Host write word |
| rdata | output | 16 | Host read word |
| rdata_oe | output | 1 | Read word drive enable |
| dta_n | output | 1 | Transfer acknowledge, active low |
| core_wr_en | input | 1 | Core write strobe for data memories |
| core_wr_sel | input | 1 | 0 backplane data, 1 local data |
| core_wr_addr | input | 12 | Core write word address |
| core_wr_data | input | 16 | Core write word |
| core_rd_sel | input | 2 | Memory code for core read |
| core_rd_addr | input | 12 | Core read word address |
| core_rd_data | output | 16 | Core read word, one cycle latency |

## Verification
Some properties are checked on every core clock cycle. The connection memories are written only in the access step of a host transaction. The data memories are never written without a core write strobe. The core acknowledge drops the cycle after the synchronized strobe goes inactive, and the machine stays parked until both strobes are seen high.

Other behaviour can only be shown by the bench's scenarios. These cover the address decode and stored contents, the dropped host writes to data memories, and the strobe sequence that re-lowers data strobe under a held chip select. They also cover the acknowledge timing measured at the pins, including the watchdog completion with the core clock stopped and recovery afterwards.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACCESS  = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_ACK     = 3'd3,
    ST_WAIT    = 3'd4
  } hbp_state_e;

  localparam int unsigned NUM_MEMS = 4;

  // memory codes carried by the host address and the core read select
  localparam logic [1:0] MEM_BP_CONN = 2'd0;
  localparam logic [1:0] MEM_BP_DATA = 2'd1;
  localparam logic [1:0] MEM_LC_CONN = 2'd2;
  localparam logic [1:0] MEM_LC_DATA = 2'd3;

endpackage

// File: rtl/hbp_rst_sync.sv
module hbp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RESET_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hbp_ram.sv
module hbp_ram #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/hbp_watchdog.sv
module hbp_watchdog #(
  parameter int unsigned LIMIT  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic wd_clk,
  input  logic arst_n,
  input  logic cs_n,
  input  logic ds_n,
  output logic wd_ack
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic          wd_rst_n;
  logic [1:0]    strb_w;
  logic          act_w;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;

  hbp_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk(wd_clk), .arst_n(arst_n), .rst_n_o(wd_rst_n)
  );

  hbp_sync #(.WIDTH(2), .STAGES(STAGES), .RESET_VAL(2'b11)) u_strb (
    .clk(wd_clk), .rst_n(wd_rst_n), .d({cs_n, ds_n}), .q(strb_w)
  );

  assign act_w = ~strb_w[1] & ~strb_w[0];

  always_comb begin
    cnt_d = cnt_q;
    ack_d = ack_q;
    if (!act_w) begin
      cnt_d = '0;
      ack_d = 1'b0;
    end else if (cnt_q == CW'(LIMIT)) begin
      ack_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ack_q <= ack_d;
    end
  end

  assign wd_ack = ack_q;

endmodule

// File: rtl/hbus_port.sv
module hbus_port
  import hbp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned MEM_AW      = 12,
  parameter int unsigned REG_NUM     = 8,
  parameter int unsigned WD_CYCLES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_clk,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              dta_n,
  input  logic              core_wr_en,
  input  logic              core_wr_sel,
  input  logic [MEM_AW-1:0] core_wr_addr,
  input  logic [DATA_W-1:0] core_wr_data,
  input  logic [1:0]        core_rd_sel,
  input  logic [MEM_AW-1:0] core_rd_addr,
  output logic [DATA_W-1:0] core_rd_data
);

  localparam int unsigned SPACE_BIT = ADDR_W - 1;
  localparam int unsigned OFFS_W    = ADDR_W - 1;
  localparam int unsigned REG_IW    = (REG_NUM > 1) ? $clog2(REG_NUM) : 1;

  // ---------------- reset and strobe synchronization ----------------
  logic       rst_core_n;
  logic [1:0] strb_s;
  logic       act_s, idle_s;

  hbp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_core (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_core_n)
  );

  hbp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_strb_sync (
    .clk(clk), .rst_n(rst_core_n), .d({cs_n, ds_n}), .q(strb_s)
  );

  assign act_s  = ~strb_s[1] & ~strb_s[0];
  assign idle_s = strb_s[1] & strb_s[0];

  // ---------------- transaction state machine ----------------
  hbp_state_e st_q, st_d;
  logic       start;

  assign start = (st_q == ST_IDLE) & act_s;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (act_s)  st_d = ST_ACCESS;
      ST_ACCESS:              st_d = ST_CAPTURE;
      ST_CAPTURE:             st_d = ST_ACK;
      ST_ACK:     if (!act_s) st_d = ST_WAIT;
      ST_WAIT:    if (idle_s) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  // ---------------- request capture ----------------
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic              lat_rw_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      lat_rw_q    <= 1'b0;
    end else if (start) begin
      lat_addr_q  <= addr;
      lat_wdata_q <= wdata;
      lat_rw_q    <= rw;
    end
  end

  logic              lat_is_mem;
  logic [1:0]        lat_sel;
  logic [MEM_AW-1:0] lat_idx;
  logic [REG_IW-1:0] lat_reg_idx;
  logic              reg_hit;
  logic              host_wr;

  assign lat_is_mem  = lat_addr_q[SPACE_BIT];
  assign lat_sel     = lat_addr_q[MEM_AW+1:MEM_AW];
  assign lat_idx     = lat_addr_q[MEM_AW-1:0];
  assign lat_reg_idx = lat_addr_q[REG_IW-1:0];
  assign reg_hit     = lat_addr_q[OFFS_W-1:0] < OFFS_W'(REG_NUM);
  assign host_wr     = (st_q == ST_ACCESS) & ~lat_rw_q;

  // ---------------- control register bank ----------------
  logic [DATA_W-1:0] reg_q [REG_NUM];

  for (genvar g = 0; g < REG_NUM; g++) begin : g_reg
    logic              wr_en;
    logic [DATA_W-1:0] val_q;

    assign wr_en = host_wr & ~lat_is_mem & reg_hit & (lat_reg_idx == REG_IW'(g));

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)  val_q <= '0;
      else if (wr_en)   val_q <= lat_wdata_q;
    end

    assign reg_q[g] = val_q;
  end

  // ---------------- memory array ----------------
  logic [NUM_MEMS-1:0] mem_we;
  logic [MEM_AW-1:0]   mem_waddr [NUM_MEMS];
  logic [DATA_W-1:0]   mem_wdata [NUM_MEMS];
  logic [DATA_W-1:0]   host_q    [NUM_MEMS];
  logic [DATA_W-1:0]   core_q    [NUM_MEMS];

  for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
    if ((m % 2) == 1) begin : g_data
      // data memory: written by the switching core only
      assign mem_we[m]    = core_wr_en & (core_wr_sel == 1'(m / 2));
      assign mem_waddr[m] = core_wr_addr;
      assign mem_wdata[m] = core_wr_data;
    end else begin : g_conn
      // connection memory: written by the host
      assign mem_we[m]    = host_wr & lat_is_mem & (lat_sel == 2'(m));
      assign mem_waddr[m] = lat_idx;
      assign mem_wdata[m] = lat_wdata_q;
    end

    hbp_ram #(.AW(MEM_AW), .DW(DATA_W)) u_ram (
      .clk    (clk),
      .we     (mem_we[m]),
      .waddr  (mem_waddr[m]),
      .wdata  (mem_wdata[m]),
      .ra_addr(lat_idx),
      .ra_data(host_q[m]),
      .rb_addr(core_rd_addr),
      .rb_data(core_q[m])
    );
  end

  // ---------------- core read return ----------------
  logic [1:0] core_sel_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) core_sel_q <= '0;
    else             core_sel_q <= core_rd_sel;
  end

  assign core_rd_data = core_q[core_sel_q];

  // ---------------- host read return ----------------
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_en;

  always_comb begin
    if (lat_is_mem)   rd_word = host_q[lat_sel];
    else if (reg_hit) rd_word = reg_q[lat_reg_idx];
    else              rd_word = '0;
  end

  assign cap_en = (st_q == ST_CAPTURE) & lat_rw_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rdata_q <= '0;
    else if (cap_en)  rdata_q <= rd_word;
  end

  assign rdata    = rdata_q;
  assign rdata_oe = ~cs_n & ~ds_n & rw;

  // ---------------- acknowledge ----------------
  logic core_ack;
  logic wd_ack;

  assign core_ack = (st_q == ST_ACK);

  hbp_watchdog #(.LIMIT(WD_CYCLES), .STAGES(SYNC_STAGES)) u_wd (
    .wd_clk(wd_clk), .arst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .wd_ack(wd_ack)
  );

  assign dta_n = ~(core_ack | wd_ack);

endmodule

// File: rtl/hbus_port_chk.sv
module hbus_port_chk
  import hbp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input hbp_state_e st,
  input logic       act_s,
  input logic       idle_s,
  input logic [3:0] mem_we,
  input logic       core_wr_en,
  input logic       core_ack
);

  // R3: connection memories change only in the access step, one at a time
  p_conn_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we[0] || mem_we[2]) |-> (st == ST_ACCESS && $onehot0({mem_we[2], mem_we[0]})));

  // R4: host transactions never touch the data memories
  p_data_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_wr_en |-> !(mem_we[1] || mem_we[3]));

  // R6: acknowledge only follows a completed capture step
  p_ack_after_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ack) |-> ($past(st) == ST_CAPTURE && act_s));

  // R7: acknowledge drops once the strobe is seen inactive
  p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && !act_s) |=> !core_ack);

  // R8: no restart until both strobes are high
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !idle_s) |=> (st == ST_WAIT));

endmodule

bind hbus_port hbus_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .st        (st_q),
  .act_s     (act_s),
  .idle_s    (idle_s),
  .mem_we    (mem_we),
  .core_wr_en(core_wr_en),
  .core_ack  (core_ack)
);

// File: tb/hbus_port_bench.sv
module hbus_port_bench;

  logic        clk = 1'b0;
  logic        wd_clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n;
  logic        cs_n, ds_n, rw;
  logic [14:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rdata_oe, dta_n;
  logic        core_wr_en, core_wr_sel;
  logic [11:0] core_wr_addr, core_rd_addr;
  logic [15:0] core_wr_data, core_rd_data;
  logic [1:0]  core_rd_sel;

  int n_checks = 0;
  int n_bad    = 0;

  always #4  clk    = clk_run ? ~clk : clk;   // 125 MHz core clock
  always #10 wd_clk = ~wd_clk;                // watchdog clock

  hbus_port u_hbus_port (
    .clk(clk), .rst_n(rst_n), .wd_clk(wd_clk),
    .cs_n(cs_n), .ds_n(ds_n), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .dta_n(dta_n),
    .core_wr_en(core_wr_en), .core_wr_sel(core_wr_sel),
    .core_wr_addr(core_wr_addr), .core_wr_data(core_wr_data),
    .core_rd_sel(core_rd_sel), .core_rd_addr(core_rd_addr), .core_rd_data(core_rd_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_access(input logic rd, input logic [14:0] a, input logic [15:0] wd,
                             output logic [15:0] rval, output logic acked,
                             output int lat_ns, output logic oe_seen);
    time t0;
    addr = a; rw = rd; wdata = wd;
    #3;
    cs_n = 1'b0; #1; ds_n = 1'b0;
    t0 = $time;
    acked = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      #1;
      if (dta_n === 1'b0) begin acked = 1'b1; break; end
    end
    lat_ns = int'($time - t0);
    #1;
    rval = rdata; oe_seen = rdata_oe;
    ds_n = 1'b1; #1; cs_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      #1;
      if (dta_n === 1'b1) break;
    end
    #5;
  endtask

  task automatic core_write(input logic sel, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    core_wr_en = 1'b1; core_wr_sel = sel; core_wr_addr = a; core_wr_data = d;
    @(negedge clk);
    core_wr_en = 1'b0;
  endtask

  // {read, address, write word, expected read word}
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 15'h4005, 16'h1234, 16'h0000},
    {1'b0, 15'h6005, 16'hABCD, 16'h0000},
    {1'b1, 15'h4005, 16'h0000, 16'h1234},
    {1'b1, 15'h6005, 16'h0000, 16'hABCD},
    {1'b0, 15'h4FFF, 16'h0F0F, 16'h0000},
    {1'b1, 15'h4FFF, 16'h0000, 16'h0F0F},
    {1'b0, 15'h4000, 16'hFFFF, 16'h0000},
    {1'b1, 15'h4000, 16'h0000, 16'hFFFF},
    {1'b1, 15'h4005, 16'h0000, 16'h1234},
    {1'b0, 15'h0003, 16'h5A5A, 16'h0000},
    {1'b1, 15'h0003, 16'h0000, 16'h5A5A},
    {1'b0, 15'h0100, 16'h7777, 16'h0000},
    {1'b1, 15'h0100, 16'h0000, 16'h0000},
    {1'b1, 15'h0000, 16'h0000, 16'h0000}
  };

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic        ok, oe;
    int          lat;

    rst_n = 1'b0; cs_n = 1'b1; ds_n = 1'b1; rw = 1'b1; addr = '0; wdata = '0;
    core_wr_en = 1'b0; core_wr_sel = 1'b0; core_wr_addr = '0; core_wr_data = '0;
    core_rd_sel = '0; core_rd_addr = '0;
    #51 rst_n = 1'b1;
    #61;

    // R11 reset state
    check("R11 dta_n after reset", {15'd0, dta_n}, 16'h0001);
    check("R11 rdata after reset", rdata, 16'h0000);
    check("R10 rdata_oe idle", {15'd0, rdata_oe}, 16'h0000);
    host_access(1'b1, 15'h0007, 16'h0, rv, ok, lat, oe);
    check("R11 register 7 after reset", rv, 16'h0000);

    // table of accesses (R1, R2, R3, R6)
    foreach (VEC[k]) begin
      host_access(VEC[k][47], VEC[k][46:32], VEC[k][31:16], rv, ok, lat, oe);
      check("R6 table ack", {15'd0, ok}, 16'h0001);
      if (VEC[k][47]) begin
        if (VEC[k][46]) check("R2 R3 table memory read", rv, VEC[k][15:0]);
        else            check("R1 table register read", rv, VEC[k][15:0]);
      end
    end

    // R6 latency and R10 drive enable
    host_access(1'b1, 15'h6005, 16'h0, rv, ok, lat, oe);
    check("R6 ack within 8 core cycles", {15'd0, lat <= 64}, 16'h0001);
    check("R6 read word at ack", rv, 16'hABCD);
    check("R10 rdata_oe during read", {15'd0, oe}, 16'h0001);
    host_access(1'b0, 15'h0001, 16'h00A1, rv, ok, lat, oe);
    check("R10 rdata_oe during write", {15'd0, oe}, 16'h0000);

    // R4 data memories
    core_write(1'b0, 12'h007, 16'hC0DE);
    core_write(1'b1, 12'h007, 16'hBEEF);
    host_access(1'b1, 15'h5007, 16'h0, rv, ok, lat, oe);
    check("R4 backplane data read", rv, 16'hC0DE);
    host_access(1'b1, 15'h7007, 16'h0, rv, ok, lat, oe);
    check("R4 local data read", rv, 16'hBEEF);
    host_access(1'b0, 15'h5007, 16'h1111, rv, ok, lat, oe);
    check("R4 data write acknowledged", {15'd0, ok}, 16'h0001);
    host_access(1'b1, 15'h5007, 16'h0, rv, ok, lat, oe);
    check("R4 data memory unchanged", rv, 16'hC0DE);

    // R5 core read port
    @(negedge clk); core_rd_sel = 2'd0; core_rd_addr = 12'h005;
    @(negedge clk); check("R5 core read backplane connection", core_rd_data, 16'h1234);
    core_rd_sel = 2'd2;
    @(negedge clk); check("R5 core read local connection", core_rd_data, 16'hABCD);
    core_rd_sel = 2'd1; core_rd_addr = 12'h007;
    @(negedge clk); check("R5 core read backplane data", core_rd_data, 16'hC0DE);
    core_rd_sel = 2'd3;
    @(negedge clk); check("R5 core read local data", core_rd_data, 16'hBEEF);

    // R7 release on data strobe alone, R8 no restart under held chip select
    addr = 15'h4005; rw = 1'b1; #3;
    cs_n = 1'b0; #1; ds_n = 1'b0;
    for (int i = 0; i < 200; i++) begin #1; if (dta_n === 1'b0) break; end
    check("R7 ack before release", {15'd0, dta_n}, 16'h0000);
    ds_n = 1'b1;
    for (int i = 0; i < 100; i++) begin #1; if (dta_n === 1'b1) break; end
    check("R7 ack released by data strobe", {15'd0, dta_n}, 16'h0001);
    rw = 1'b0; wdata = 16'h9999; #20;
    ds_n = 1'b0;
    #200;
    check("R8 no ack without both strobes idle", {15'd0, dta_n}, 16'h0001);
    ds_n = 1'b1; #1; cs_n = 1'b1;
    #100;
    host_access(1'b1, 15'h4005, 16'h0, rv, ok, lat, oe);
    check("R8 no write without both strobes idle", rv, 16'h1234);

    // R9 watchdog completion with the core clock stopped
    clk_run = 1'b0;
    #20;
    host_access(1'b1, 15'h4005, 16'h0, rv, ok, lat, oe);
    check("R9 ack without core clock", {15'd0, ok}, 16'h0001);
    check("R9 watchdog delay window", {15'd0, (lat >= 600) && (lat <= 1000)}, 16'h0001);
    clk_run = 1'b1;
    #60;
    host_access(1'b1, 15'h4005, 16'h0, rv, ok, lat, oe);
    check("R9 recovery read", rv, 16'h1234);
    check("R9 recovery fast ack", {15'd0, lat <= 64}, 16'h0001);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule